// File: doc/BRIEF.md
# Atomic Test-and-Set Lock Unit

This block holds a small bank of one-bit lock flags that several requesters share. Each requester owns a request port with a valid/ready handshake, a two-bit operation code and a lock index. The operations are an atomic test-and-set, a plain release write and a non-destructive read. A flag at zero means the lock is free; a flag at one means it is held.

A fixed-priority arbiter admits exactly one request per clock cycle. It always favours the lowest-numbered requester that has a valid request. The admitted operation reads the addressed flag and updates it in that same cycle, so no other requester can act on the flag between the read and the write. The value the flag held before the operation goes back to the admitted requester one cycle later, on that requester's own response strobe.

A test-and-set that returns zero has acquired the lock. One that returns one has failed, and the requester can simply issue it again. A requester may hold its valid high across many cycles; each cycle in which it is granted counts as one complete operation.

Top module: `tas_lock_unit`

## Requirements
- R1: While reset is high, every reqReady bit is 0. After reset, every lock reads as free (0) and every rspValid bit is 0.
- R2: A test-and-set (op code 1) on a free lock returns prior value 0, and the lock holds 1 afterwards.
- R3: A test-and-set on a held lock returns prior value 1, and the lock stays at 1.
- R4: A release (op code 2) writes 0 to the lock and returns the value the lock held before the write.
- R5: A read (op code 0) returns the current lock value and leaves every lock unchanged.
- R6: In each cycle, reqReady grants at most one requester. The grant goes to the lowest-indexed requester whose reqValid is high, and it is never given to a requester whose reqValid is low.
- R7: Exactly one cycle after a grant, rspValid pulses high for the granted requester only, and rspPrior carries that requester's result.
- R8: A requester that keeps reqValid high is served again on every cycle in which it wins arbitration. Each repeat is a separate operation.
- R9: When several requesters issue test-and-set to one free lock at the same time, exactly one of them receives prior value 0.
- R10: An operation changes only the lock it addresses; all other locks keep their values.
- R11: Op code 3 behaves like a read: it returns the lock value and changes nothing.
- R12: A release and a test-and-set that target the same lock in the same cycle are both carried out, one after the other, in priority order; neither is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | NUM_REQ | Per-requester request valid |
| reqOp | input | 2*NUM_REQ | Per-requester op code (0 read, 1 test-and-set, 2 release, 3 read) |
| reqIdx | input | NUM_REQ*IDX_W | Per-requester lock index |
| reqReady | output | NUM_REQ | Per-requester grant, at most one bit high |
| rspValid | output | NUM_REQ | Per-requester response strobe, one cycle after the grant |
| rspPrior | output | NUM_REQ | Lock value observed before the granted operation |

## Verification
The bench sweeps every combination of valid requesters with rotating op codes and lock indices. Against each of them it checks that the grant picks the lowest active index. An arbiter that granted two requesters, or picked the wrong one, would return a stale prior value or show two bits in reqReady. Four requesters attack one free lock together, to catch a design that lets more than one of them see zero. A release and a test-and-set collide on the same lock, to expose a design that drops the lower-priority request. A requester holds valid high over several cycles, which would reveal a design that serves a held request only once. Reads and op code 3 are followed by later reads of every lock, so a read that disturbs state is caught.

// File: rtl/tas_lock_pkg.sv
package tas_lock_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_TAS  = 2'd1,
    OP_REL  = 2'd2,
    OP_RSVD = 2'd3
  } lockOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic fire;     // a request was granted this cycle
    logic lockWe;   // write the addressed lock
    logic lockVal;  // value to write
  } lockStrobe_t;

endpackage

// File: rtl/tas_lock_ctrl.sv
module tas_lock_ctrl
  import tas_lock_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = 2
) (
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       reqValid,
  input  logic [2*NUM_REQ-1:0]     reqOp,
  input  logic [NUM_REQ*IDX_W-1:0] reqIdx,
  output logic [NUM_REQ-1:0]       grant,
  output logic [IDX_W-1:0]         winIdx,
  output logic [1:0]               winOp,
  output lockStrobe_t              strobe
);

  // blocked[i] is high when reset is active or a lower index is valid
  logic [NUM_REQ:0] blocked;
  assign blocked[0] = rst;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REQ; gi++) begin : gPrio
      assign grant[gi]       = reqValid[gi] & ~blocked[gi];
      assign blocked[gi + 1] = blocked[gi] | reqValid[gi];
    end
  endgenerate

  // One-hot mux of the winner's op and index
  always_comb begin
    winIdx = '0;
    winOp  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      winIdx = winIdx | (reqIdx[i*IDX_W +: IDX_W] & {IDX_W{grant[i]}});
      winOp  = winOp  | (reqOp[2*i +: 2] & {2{grant[i]}});
    end
  end

  always_comb begin
    strobe.fire    = |grant;
    strobe.lockWe  = strobe.fire &&
                     (winOp == OP_TAS || winOp == OP_REL);
    strobe.lockVal = (winOp == OP_TAS);
  end

endmodule

// File: rtl/tas_lock_dp.sv
module tas_lock_dp
  import tas_lock_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int NUM_LOCKS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  lockStrobe_t          strobe,
  input  logic [NUM_REQ-1:0]   grant,
  input  logic [IDX_W-1:0]     winIdx,
  output logic [NUM_LOCKS-1:0] lockBank,
  output logic [NUM_REQ-1:0]   rspValid,
  output logic [NUM_REQ-1:0]   rspPrior
);

  logic priorBit;
  assign priorBit = lockBank[winIdx];

  genvar gl;
  generate
    for (gl = 0; gl < NUM_LOCKS; gl++) begin : gLock
      always_ff @(posedge clk) begin
        if (rst)
          lockBank[gl] <= 1'b0;
        else if (strobe.lockWe && (winIdx == IDX_W'(gl)))
          lockBank[gl] <= strobe.lockVal;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= '0;
      rspPrior <= '0;
    end else begin
      rspValid <= grant;
      rspPrior <= {NUM_REQ{priorBit}} & grant;
    end
  end

endmodule

// File: rtl/tas_lock_unit.sv
module tas_lock_unit
  import tas_lock_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int NUM_LOCKS = 4,
  parameter int IDX_W     = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       reqValid,
  input  logic [2*NUM_REQ-1:0]     reqOp,
  input  logic [NUM_REQ*IDX_W-1:0] reqIdx,
  output logic [NUM_REQ-1:0]       reqReady,
  output logic [NUM_REQ-1:0]       rspValid,
  output logic [NUM_REQ-1:0]       rspPrior
);

  lockStrobe_t          strobe;
  logic [NUM_REQ-1:0]   grant;
  logic [IDX_W-1:0]     winIdx;
  logic [1:0]           winOp;
  logic [NUM_LOCKS-1:0] lockBank;

  tas_lock_ctrl #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) ctrl_i (
    .rst      (rst),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqIdx   (reqIdx),
    .grant    (grant),
    .winIdx   (winIdx),
    .winOp    (winOp),
    .strobe   (strobe)
  );

  tas_lock_dp #(.NUM_REQ(NUM_REQ), .NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .grant    (grant),
    .winIdx   (winIdx),
    .lockBank (lockBank),
    .rspValid (rspValid),
    .rspPrior (rspPrior)
  );

  assign reqReady = grant;

endmodule

// File: rtl/tas_lock_chk.sv
module tas_lock_chk #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_LOCKS = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_REQ-1:0]   reqValid,
  input logic [NUM_REQ-1:0]   reqReady,
  input logic [NUM_REQ-1:0]   rspValid,
  input logic [NUM_LOCKS-1:0] lockBank,
  input logic [IDX_W-1:0]     winIdx,
  input logic [1:0]           winOp
);

  logic fire;
  assign fire = |(reqValid & reqReady);

  a_r6_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqReady));

  a_r6_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (reqReady & ~reqValid) == '0);

  a_r1_no_grant_in_reset: assert property (@(posedge clk)
    rst |-> reqReady == '0);

  a_r7_rsp_follows_grant: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rspValid == $past(reqReady));

  a_r2_tas_sets: assert property (@(posedge clk) disable iff (rst)
    (fire && winOp == 2'd1) |=> lockBank[$past(winIdx)]);

  a_r4_release_clears: assert property (@(posedge clk) disable iff (rst)
    (fire && winOp == 2'd2) |=> !lockBank[$past(winIdx)]);

  a_r5_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (!fire || winOp == 2'd0 || winOp == 2'd3) |=> $stable(lockBank));

endmodule

bind tas_lock_unit tas_lock_chk #(
  .NUM_REQ(NUM_REQ), .NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .lockBank (lockBank),
  .winIdx   (winIdx),
  .winOp    (winOp)
);

// File: tb/tas_lock_unit_tb_top.sv
module tas_lock_unit_tb_top;

  localparam int NR = 4;
  localparam int NL = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NR-1:0]    reqValid = '0;
  logic [2*NR-1:0]  reqOp = '0;
  logic [NR*IW-1:0] reqIdx = '0;
  logic [NR-1:0]    reqReady, rspValid, rspPrior;

  int checks = 0;
  int errors = 0;
  bit model [NL];
  int lastWin;
  bit lastPrior;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tas_lock_unit #(.NUM_REQ(NR), .NUM_LOCKS(NL)) dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp), .reqIdx(reqIdx),
    .reqReady(reqReady), .rspValid(rspValid), .rspPrior(rspPrior)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle of requests at a falling edge, check grant and response
  task automatic step(input logic [NR-1:0] v, input logic [2*NR-1:0] ops,
                      input logic [NR*IW-1:0] ids);
    int win;
    logic [NR-1:0] expGrant;
    logic [1:0] op;
    int id;
    bit exp;
    string tag;
    win = -1;
    for (int i = 0; i < NR; i++) if (v[i] && win < 0) win = i;
    expGrant = (win >= 0) ? NR'(1 << win) : '0;
    reqValid = v; reqOp = ops; reqIdx = ids;
    #1;
    check(reqReady == expGrant, "R6 grant", 32'(reqReady), 32'(expGrant));
    @(posedge clk);
    @(negedge clk);
    check(rspValid == expGrant, "R7 response", 32'(rspValid), 32'(expGrant));
    lastWin = win;
    if (win >= 0) begin
      op  = ops[2*win +: 2];
      id  = int'(ids[IW*win +: IW]);
      exp = model[id];
      case (op)
        2'd1: tag = exp ? "R3 tas held" : "R2 tas free";
        2'd2: tag = "R4 release";
        2'd0: tag = "R5 read";
        default: tag = "R11 code3";
      endcase
      lastPrior = rspPrior[win];
      check(rspPrior[win] == exp, tag, 32'(rspPrior[win]), 32'(exp));
      if (op == 2'd1) model[id] = 1'b1;
      if (op == 2'd2) model[id] = 1'b0;
    end
  endtask

  task automatic single(input int r, input logic [1:0] op, input int id);
    logic [NR-1:0] v;
    logic [2*NR-1:0] ops;
    logic [NR*IW-1:0] ids;
    v = '0; ops = '0; ids = '0;
    v[r] = 1'b1;
    ops[2*r +: 2] = op;
    ids[IW*r +: IW] = IW'(id);
    step(v, ops, ids);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int zeros;
    logic [2*NR-1:0] ops;
    logic [NR*IW-1:0] ids;
    for (int l = 0; l < NL; l++) model[l] = 1'b0;
    // R1: requests during reset are not granted
    @(negedge clk);
    reqValid = '1;
    #1;
    check(reqReady == '0, "R1 ready in reset", 32'(reqReady), 0);
    @(negedge clk);
    reqValid = '0;
    rst = 1'b0;
    #1;
    check(rspValid == '0, "R1 rsp after reset", 32'(rspValid), 0);
    for (int l = 0; l < NL; l++) begin
      single(l % NR, 2'd0, l);
      check(lastPrior == 1'b0, "R1 lock free", 32'(lastPrior), 0);
    end

    // R10: one lock taken, others untouched
    single(0, 2'd1, 0);
    single(1, 2'd0, 1);
    check(lastPrior == 1'b0, "R10 neighbour", 32'(lastPrior), 0);
    single(2, 2'd3, 0);
    check(lastPrior == 1'b1, "R11 read value", 32'(lastPrior), 1);
    single(3, 2'd2, 0);

    // R8: held request served every cycle
    single(0, 2'd1, 2);
    check(lastPrior == 1'b0, "R8 first", 32'(lastPrior), 0);
    single(0, 2'd1, 2);
    check(lastPrior == 1'b1, "R8 repeat", 32'(lastPrior), 1);
    single(0, 2'd1, 2);
    check(lastWin == 0, "R8 served", 32'(lastWin), 0);

    // R9: four test-and-sets on free lock 3
    ops = {2'd1, 2'd1, 2'd1, 2'd1};
    ids = {2'd3, 2'd3, 2'd3, 2'd3};
    zeros = 0;
    step(4'b1111, ops, ids); if (!lastPrior) zeros++;
    step(4'b1110, ops, ids); if (!lastPrior) zeros++;
    step(4'b1100, ops, ids); if (!lastPrior) zeros++;
    step(4'b1000, ops, ids); if (!lastPrior) zeros++;
    check(zeros == 1, "R9 single winner", 32'(zeros), 1);

    // R12: release and test-and-set collide on lock 3
    ops = {2'd0, 2'd0, 2'd1, 2'd2};
    step(4'b0011, ops, ids);
    check(lastWin == 0, "R12 release first", 32'(lastWin), 0);
    step(4'b0010, ops, ids);
    check(lastWin == 1 && lastPrior == 1'b0, "R12 tas kept", 32'(lastPrior), 0);

    // Sweep over every valid mask with rotating ops and indices
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 4; k++) begin
        for (int i = 0; i < NR; i++) begin
          ops[2*i +: 2]  = 2'((i + k) % 4);
          ids[IW*i +: IW] = IW'((i * m + k + i) % NL);
        end
        step(NR'(m), ops, ids);
      end
    end

    // Final state readback of all locks (R5, R10)
    for (int l = 0; l < NL; l++) single(3, 2'd0, l);

    reqValid = '0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule